// File: doc/BRIEF.md
# Dual I/O Serial Flash Read Responder

This block is the memory-side engine of a serial flash for the dual I/O read. The host selects the device by pulling chip select low and sends an 8-bit opcode on IO0. The address then arrives two bits per rising SCK edge on IO1 and IO0. After a configurable number of dummy clocks, the block returns array bytes two bits per falling SCK edge.

The address advances by one after every byte. A single command can therefore stream the whole array, wrapping from the top address back to zero. Array bytes come from a synchronous byte-read port: a request pulse with an address, answered with data one clock later.

SCK, chip select and the IO inputs are taken as already synchronous to `clk_i`. Each SCK half period must last at least four `clk_i` cycles. Edges are found by comparing SCK with its value one clock earlier.

Top module: `dio_read_responder`

## Requirements
- R1: After reset, both IO output enables are low and no memory request is issued.
- R2: Opcode 8'hBB with `ext_addr_i` = 0 is followed by a 3-byte address.
- R3: Opcode 8'hBB with `ext_addr_i` = 1 is followed by a 4-byte address.
- R4: Opcode 8'hBC is always followed by a 4-byte address, whatever the value of `ext_addr_i`.
- R5: The opcode is taken MSB first, one bit per rising edge on IO0. Any opcode other than 8'hBB or 8'hBC is ignored until chip select rises: IO stays released and no memory request is made.
- R6: Each address pair is taken on a rising edge, MSB first, with IO1 carrying the higher bit and IO0 the lower bit. Only the low `ARRAY_AW` bits of the address select the byte.
- R7: Exactly `dummy_cycles_i` rising edges follow the address. IO0 and IO1 stay released during these edges.
- R8: Data starts on the falling edge that follows the last address or dummy rising edge. Each byte is sent as four pairs, MSB pair first, with IO1 carrying the higher bit of each pair.
- R9: Each further byte comes from the previous address plus one.
- R10: After address 2^`ARRAY_AW`-1, reading continues at address 0 within the same command.
- R11: Chip select high ends any transaction at any point. IO is released while chip select is high, and the next command decodes from scratch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock, synchronous to clk_i |
| cs_ni | input | 1 | Active-low chip select |
| io_i | input | 2 | IO1/IO0 input values |
| io_o | output | 2 | IO1/IO0 output values |
| io_oe_o | output | 2 | IO1/IO0 output enables |
| ext_addr_i | input | 1 | Makes opcode 8'hBB take a 4-byte address |
| dummy_cycles_i | input | DUMMY_W | Number of dummy clocks after the address |
| mem_req_o | output | 1 | Byte-read request pulse |
| mem_addr_o | output | ARRAY_AW | Byte-read address |
| mem_rdata_i | input | 8 | Byte returned one clock after the request |

## Verification
At a byte boundary, the reload of the output shifter and the address increment for the prefetch fall in the same clock. When the increment also overflows the array, that same clock must wrap the address to zero. The wrap test provokes this by starting at the second-highest address and reading three bytes. The third byte must equal the content at address 0, with no gap or repeated pair in the serial stream. An aborted command followed by a fresh one checks that chip select overrides a data phase in progress.

// File: rtl/dio_read_pkg.sv
package dio_read_pkg;
  typedef enum logic [2:0] {
    RX_OPC,
    RX_ADDR,
    RX_DUMMY,
    RX_DATA,
    RX_SKIP
  } rx_state_e;

  localparam logic [7:0] OPC_DIO_RD    = 8'hBB;
  localparam logic [7:0] OPC_DIO_RD_4B = 8'hBC;
endpackage

// File: rtl/dio_sck_edge.sv
module dio_sck_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  output logic rise_o,
  output logic fall_o
);
  logic sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_q <= 1'b0;
    else         sck_q <= sck_i;
  end

  assign rise_o = sck_i & ~sck_q;
  assign fall_o = ~sck_i & sck_q;
endmodule

// File: rtl/dio_cmd_rx.sv
module dio_cmd_rx
  import dio_read_pkg::*;
#(
  parameter int ARRAY_AW = 24,
  parameter int DUMMY_W  = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cs_ni,
  input  logic                rise_i,
  input  logic [1:0]          io_i,
  input  logic                ext_addr_i,
  input  logic [DUMMY_W-1:0]  dummy_cycles_i,
  output logic                addr_done_o,
  output logic [ARRAY_AW-1:0] addr_o,
  output logic                data_phase_o
);
  localparam int SH_W = ARRAY_AW;  // must be >= 8: opcode shares the register

  rx_state_e           state_q;
  logic [4:0]          cnt_q;
  logic [DUMMY_W-1:0]  dcnt_q;
  logic [SH_W-1:0]     sh_q;
  logic                four_q;
  logic [7:0]          opc;
  logic [SH_W-1:0]     sh_nxt;
  logic [4:0]          last_pair;

  assign opc       = {sh_q[6:0], io_i[0]};
  assign sh_nxt    = {sh_q[SH_W-3:0], io_i[1], io_i[0]};  // high address bits fall off
  assign last_pair = four_q ? 5'd15 : 5'd11;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_OPC;
      cnt_q   <= '0;
      dcnt_q  <= '0;
      sh_q    <= '0;
      four_q  <= 1'b0;
    end else if (cs_ni) begin
      state_q <= RX_OPC;
      cnt_q   <= '0;
      dcnt_q  <= '0;
      sh_q    <= '0;
      four_q  <= 1'b0;
    end else if (rise_i) begin
      unique case (state_q)
        RX_OPC: begin
          sh_q  <= {sh_q[SH_W-2:0], io_i[0]};
          cnt_q <= cnt_q + 5'd1;
          if (cnt_q == 5'd7) begin
            cnt_q <= '0;
            sh_q  <= '0;
            if (opc == OPC_DIO_RD) begin
              four_q  <= ext_addr_i;
              state_q <= RX_ADDR;
            end else if (opc == OPC_DIO_RD_4B) begin
              four_q  <= 1'b1;
              state_q <= RX_ADDR;
            end else begin
              state_q <= RX_SKIP;
            end
          end
        end
        RX_ADDR: begin
          sh_q  <= sh_nxt;
          cnt_q <= cnt_q + 5'd1;
          if (cnt_q == last_pair) begin
            cnt_q   <= '0;
            state_q <= (dummy_cycles_i == '0) ? RX_DATA : RX_DUMMY;
          end
        end
        RX_DUMMY: begin
          dcnt_q <= dcnt_q + DUMMY_W'(1);
          if (dcnt_q == dummy_cycles_i - DUMMY_W'(1)) state_q <= RX_DATA;
        end
        default: ;
      endcase
    end
  end

  assign addr_done_o  = rise_i & ~cs_ni & (state_q == RX_ADDR) & (cnt_q == last_pair);
  assign addr_o       = sh_nxt;
  assign data_phase_o = (state_q == RX_DATA);

  // R5: a rejected opcode keeps the decoder parked until chip select rises
  a_r5_skip_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RX_SKIP && !cs_ni) |=> state_q == RX_SKIP);
endmodule

// File: rtl/dio_data_tx.sv
module dio_data_tx (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_ni,
  input  logic       fall_i,
  input  logic       active_i,
  input  logic [7:0] byte_i,
  output logic [1:0] io_o,
  output logic       drive_o,
  output logic       load_o
);
  logic [7:0] sh_q;
  logic [1:0] pair_q;
  logic       drive_q;

  assign load_o = fall_i & active_i & ~cs_ni & (pair_q == 2'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      pair_q  <= '0;
      drive_q <= 1'b0;
    end else if (cs_ni) begin
      pair_q  <= '0;
      drive_q <= 1'b0;
    end else if (fall_i && active_i) begin
      sh_q    <= load_o ? byte_i : {sh_q[5:0], 2'b00};
      pair_q  <= pair_q + 2'd1;
      drive_q <= 1'b1;
    end
  end

  assign io_o    = sh_q[7:6];
  assign drive_o = drive_q;

  // R8: the first pair of every byte is its top two bits
  a_r8_msb_pair_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> io_o == $past(byte_i[7:6]));
endmodule

// File: rtl/dio_read_responder.sv
module dio_read_responder #(
  parameter int ARRAY_AW = 24,
  parameter int DUMMY_W  = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sck_i,
  input  logic                cs_ni,
  input  logic [1:0]          io_i,
  output logic [1:0]          io_o,
  output logic [1:0]          io_oe_o,
  input  logic                ext_addr_i,
  input  logic [DUMMY_W-1:0]  dummy_cycles_i,
  output logic                mem_req_o,
  output logic [ARRAY_AW-1:0] mem_addr_o,
  input  logic [7:0]          mem_rdata_i
);
  logic                rise, fall;
  logic                addr_done, data_phase, load, drive;
  logic [ARRAY_AW-1:0] addr_w, rd_addr_q;
  logic                fetch_q, fill_q;
  logic [7:0]          buf_q;

  dio_sck_edge i_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sck_i  (sck_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  dio_cmd_rx #(.ARRAY_AW(ARRAY_AW), .DUMMY_W(DUMMY_W)) i_rx (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .cs_ni          (cs_ni),
    .rise_i         (rise),
    .io_i           (io_i),
    .ext_addr_i     (ext_addr_i),
    .dummy_cycles_i (dummy_cycles_i),
    .addr_done_o    (addr_done),
    .addr_o         (addr_w),
    .data_phase_o   (data_phase)
  );

  dio_data_tx i_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_ni    (cs_ni),
    .fall_i   (fall),
    .active_i (data_phase),
    .byte_i   (buf_q),
    .io_o     (io_o),
    .drive_o  (drive),
    .load_o   (load)
  );

  // Fetch on address completion, prefetch the next byte whenever one is loaded
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_addr_q <= '0;
      fetch_q   <= 1'b0;
      fill_q    <= 1'b0;
      buf_q     <= '0;
    end else begin
      fetch_q <= 1'b0;
      fill_q  <= fetch_q;
      if (fill_q) buf_q <= mem_rdata_i;
      if (addr_done) begin
        rd_addr_q <= addr_w;
        fetch_q   <= 1'b1;
      end else if (load) begin
        rd_addr_q <= rd_addr_q + 1'b1;  // wraps at the array top
        fetch_q   <= 1'b1;
      end
    end
  end

  assign mem_req_o  = fetch_q;
  assign mem_addr_o = rd_addr_q;
  assign io_oe_o    = {2{drive & ~cs_ni}};

  // R9/R10: each prefetch targets the next address, modulo the array size
  a_r9_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && !addr_done) |=> mem_addr_o == $past(mem_addr_o) + 1'b1);

  // R7: IO released outside the data phase
  a_r7_released_outside_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_phase |-> io_oe_o == 2'b00);

  // R11: chip select rising ends the data phase
  a_r11_cs_ends_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_ni) |=> !data_phase);
endmodule

// File: tb/test_dio_read_responder.sv
`timescale 1ns/1ps
module test_dio_read_responder;
  localparam int AW = 24;
  localparam int DW = 4;
  localparam int H  = 4;  // clk cycles per SCK half period

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sck = 1'b0;
  logic          cs_n = 1'b1;
  logic [1:0]    io_in = '0;
  logic [1:0]    io_out, io_oe;
  logic          ext = 1'b0;
  logic [DW-1:0] dummy = '0;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_rdata = '0;

  int total = 0;
  int bad = 0;
  int req_cnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dio_read_responder #(.ARRAY_AW(AW), .DUMMY_W(DW)) i_dio_read_responder (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n), .io_i(io_in),
    .io_o(io_out), .io_oe_o(io_oe), .ext_addr_i(ext), .dummy_cycles_i(dummy),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata)
  );

  function automatic logic [7:0] pattern(logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
  endfunction

  always @(posedge clk) begin
    if (mem_req) begin
      mem_rdata <= pattern(mem_addr);
      req_cnt   <= req_cnt + 1;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc_out(logic [1:0] v);
    io_in = v;
    repeat (H) @(negedge clk);
    sck = 1'b1;
    repeat (H) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic cyc_in(output logic [1:0] v, output logic oe_ok);
    repeat (H) @(negedge clk);
    v = io_out;
    oe_ok = (io_oe == 2'b11);
    sck = 1'b1;
    repeat (H) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic start_cmd(logic [7:0] op, logic [31:0] addr, int abytes);
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 7; i >= 0; i--) cyc_out({1'b0, op[i]});
    for (int i = abytes * 4 - 1; i >= 0; i--) cyc_out({addr[2*i+1], addr[2*i]});
  endtask

  task automatic end_cmd();
    cs_n = 1'b1;
    io_in = '0;
    repeat (2 * H) @(negedge clk);
  endtask

  task automatic read_check(string req, logic [AW-1:0] a0, int n);
    for (int b = 0; b < n; b++) begin
      logic [7:0] got;
      logic ok_all;
      ok_all = 1'b1;
      got = '0;
      for (int p = 0; p < 4; p++) begin
        logic [1:0] v;
        logic ok;
        cyc_in(v, ok);
        got = {got[5:0], v};
        ok_all &= ok;
      end
      check(req, {ok_all, got}, {1'b1, pattern(a0 + AW'(b))});
    end
  endtask

  task automatic t_reset();
    check("R1 oe", io_oe, 0);
    check("R1 req", req_cnt, 0);
  endtask

  task automatic t_bb3();  // R2 R6 R8 R9
    ext = 1'b0; dummy = '0;
    start_cmd(8'hBB, 32'h0012_3456, 3);
    read_check("R2/R8/R9 bb 3-byte", 24'h123456, 4);
    end_cmd();
  endtask

  task automatic t_bb4();  // R3 R6
    ext = 1'b1; dummy = '0;
    start_cmd(8'hBB, 32'hAB00_FF10, 4);
    read_check("R3/R6 bb 4-byte", 24'h00FF10, 2);
    end_cmd();
  endtask

  task automatic t_bc();  // R4
    ext = 1'b0; dummy = '0;
    start_cmd(8'hBC, 32'h7E00_2233, 4);
    read_check("R4 bc 4-byte", 24'h002233, 2);
    end_cmd();
  endtask

  task automatic t_dummy();  // R7
    logic quiet;
    ext = 1'b0; dummy = 4'd5;
    start_cmd(8'hBB, 32'h0000_0100, 3);
    quiet = 1'b1;
    for (int i = 0; i < 5; i++) begin
      io_in = 2'b11;
      repeat (H) @(negedge clk);
      if (io_oe != 2'b00) quiet = 1'b0;
      sck = 1'b1;
      repeat (H) @(negedge clk);
      if (io_oe != 2'b00) quiet = 1'b0;
      sck = 1'b0;
    end
    check("R7 dummy released", quiet, 1);
    read_check("R7 data after dummy", 24'h000100, 2);
    end_cmd();
    dummy = '0;
  endtask

  task automatic t_wrap();  // R10
    ext = 1'b0;
    start_cmd(8'hBB, 32'h00FF_FFFE, 3);
    read_check("R10 wrap", 24'hFFFFFE, 3);
    end_cmd();
  endtask

  task automatic t_bad_op();  // R5
    int r0;
    logic quiet;
    r0 = req_cnt;
    quiet = 1'b1;
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 7; i >= 0; i--) cyc_out({1'b0, 8'h3B >> i});
    for (int i = 0; i < 24; i++) begin
      cyc_out(2'b10);
      if (io_oe != 2'b00) quiet = 1'b0;
    end
    check("R5 ignored no drive", quiet, 1);
    check("R5 ignored no request", req_cnt, r0);
    end_cmd();
  endtask

  task automatic t_abort();  // R11
    logic [1:0] v;
    logic ok;
    ext = 1'b0;
    start_cmd(8'hBB, 32'h0040_0000, 3);
    read_check("R11 before abort", 24'h400000, 1);
    cyc_in(v, ok);
    cyc_in(v, ok);
    cs_n = 1'b1;
    #1;
    check("R11 release on cs", io_oe, 0);
    repeat (2 * H) @(negedge clk);
    check("R11 stays released", io_oe, 0);
    start_cmd(8'hBC, 32'h0000_0ABC, 4);
    read_check("R11 fresh command", 24'h000ABC, 2);
    end_cmd();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_bb3();
    t_bb4();
    t_bc();
    t_dummy();
    t_wrap();
    t_bad_op();
    t_abort();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule